// File: doc/BRIEF.md
# Time-Slot Power Sequencer

This block brings a group of power-rail enable outputs and one clock-enable output up and down in a programmed order. Each output has a 4-bit slot number for power-up and another for power-down. When the active request rises, the block steps through numbered time slots and raises every output that belongs to the slot just finished. It then holds an active-low reset output for a programmed delay before it releases it. When the request falls, reset is asserted at once and the outputs are lowered slot by slot in their power-down order.

Slot length and reset delay are counted in microsecond ticks, which arrive as single-cycle pulses on a tick input. A slot lasts code×step + step/2, with a step of 250 µs or 1000 µs. A failsafe input drops every output and reset regardless of the mapping.

Top module: `pwr_slot_seq`

## Requirements
- R1: A slot lasts slot_code×S + S/2 tick pulses, where S is 250 when step_long is 0 and 1000 when it is 1. Code 0 therefore gives 125 or 500 ticks.
- R2: Output i's power-up slot is up_slot[4*i+3:4*i] and its power-down slot is dn_slot[4*i+3:4*i]. An output with slot k (1..15) changes at the end of the k-th slot after the sequence starts. An output with slot 0 keeps its previous level through that sequence.
- R3: During power-up, each mapped enable output is driven high, and no enable output falls.
- R4: During power-down, each mapped enable output is driven low, and no enable output rises.
- R5: clk_en follows the same scheme through clk_up_slot and clk_dn_slot. It is enabled in its power-up slot and disabled in its power-down slot.
- R6: rst_out_n stays low during power-up and is released a reset delay after the end of the last used power-up slot. It goes low on the first clock edge after act_req is seen low in the active state. It is high only in the active state.
- R7: While failsafe is high, all enable outputs, clk_en and rst_out_n are low one clock later, state reads 00, and no sequence starts.
- R8: state reads 00 in shutdown, 01 while powering up (slots and reset delay), 11 when active, and 10 while powering down. busy is high only while slots are being stepped.
- R9: A sequence runs only up to its highest used slot number, and runs one slot time when no output is mapped. Outside slot stepping the outputs do not change.
- R10: If act_req reverses during slot stepping, the current slot is finished, including its toggles, and the opposite sequence then starts from slot 1.
- R11: The reset delay is 100×2^n ticks for rst_dly_code n = 0..7 and 1000×2^(n-8) ticks for n = 8..15.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_us | input | 1 | One-cycle pulse per microsecond |
| act_req | input | 1 | Active (1) / shutdown (0) request |
| failsafe | input | 1 | Force all outputs low |
| up_slot | input | 4*N_EN | Power-up slot per enable output |
| dn_slot | input | 4*N_EN | Power-down slot per enable output |
| clk_up_slot | input | 4 | Power-up slot of clock enable |
| clk_dn_slot | input | 4 | Power-down slot of clock enable |
| slot_code | input | 8 | Slot time code |
| step_long | input | 1 | Step select: 0 = 250, 1 = 1000 ticks |
| rst_dly_code | input | 4 | Reset delay code |
| en_out | output | N_EN | Enable outputs |
| clk_en | output | 1 | Clock enable output |
| rst_out_n | output | 1 | Active-low reset output |
| busy | output | 1 | Slot stepping in progress |
| state | output | 2 | Sequencer state code |

## Verification
The properties assume that the slot mappings, slot code, step select and delay code hold still while a sequence runs, and that failsafe and act_req are synchronous to clk. The stimulus therefore changes configuration only in shutdown, drives every input at the falling edge, and holds tick_us high throughout, so that one tick equals one cycle and the measured edge positions can be compared exactly with the R1 and R11 formulas.

// File: rtl/pseq_pkg.sv
package pseq_pkg;

    typedef enum logic [2:0] {
        PH_OFF  = 3'd0,
        PH_UP   = 3'd1,
        PH_HOLD = 3'd2,
        PH_ON   = 3'd3,
        PH_DOWN = 3'd4
    } phase_e;

    // slot length in ticks: code * step + step / 2
    function automatic int unsigned slot_ticks(input logic [7:0] code, input logic long_sel,
                                               input int unsigned step_s, input int unsigned step_l);
        int unsigned step;
        step = long_sel ? step_l : step_s;
        return int'(code) * step + step / 2;
    endfunction

    // reset delay: two binary ladders selected by the top code bit
    function automatic int unsigned rst_ticks(input logic [3:0] code,
                                              input int unsigned base_s, input int unsigned base_l);
        return code[3] ? (base_l << code[2:0]) : (base_s << code[2:0]);
    endfunction

endpackage

// File: rtl/pseq_timer.sv
module pseq_timer #(
    parameter int TMR_W = 18
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             clr,
    input  logic [TMR_W-1:0] limit,
    output logic             done
);
    logic [TMR_W-1:0] cnt_d, cnt_q;
    logic             at_end;

    assign at_end = (cnt_q >= limit - TMR_W'(1));
    assign done   = tick && at_end;

    always_comb begin
        cnt_d = cnt_q;
        if (clr || done) begin
            cnt_d = '0;
        end else if (tick) begin
            cnt_d = cnt_q + TMR_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/pseq_len.sv
module pseq_len
    import pseq_pkg::*;
#(
    parameter int TMR_W      = 18,
    parameter int STEP_S_US  = 250,
    parameter int STEP_L_US  = 1000,
    parameter int RBASE_S_US = 100,
    parameter int RBASE_L_US = 1000
) (
    input  logic [7:0]       slot_code,
    input  logic             step_long,
    input  logic [3:0]       rst_dly_code,
    output logic [TMR_W-1:0] slot_len,
    output logic [TMR_W-1:0] rst_len
);
    always_comb begin
        slot_len = TMR_W'(slot_ticks(slot_code, step_long, STEP_S_US, STEP_L_US));
        rst_len  = TMR_W'(rst_ticks(rst_dly_code, RBASE_S_US, RBASE_L_US));
    end
endmodule

// File: rtl/pseq_slot_map.sv
module pseq_slot_map #(
    parameter int N_OUT  = 13,
    parameter int SLOT_W = 4
) (
    input  logic [SLOT_W-1:0]       cur_slot,
    input  logic [N_OUT*SLOT_W-1:0] up_cfg,
    input  logic [N_OUT*SLOT_W-1:0] dn_cfg,
    output logic [N_OUT-1:0]        up_hit,
    output logic [N_OUT-1:0]        dn_hit,
    output logic [SLOT_W-1:0]       up_last,
    output logic [SLOT_W-1:0]       dn_last
);
    for (genvar i = 0; i < N_OUT; i++) begin : g_out
        logic [SLOT_W-1:0] u, d;
        assign u = up_cfg[i*SLOT_W +: SLOT_W];
        assign d = dn_cfg[i*SLOT_W +: SLOT_W];
        assign up_hit[i] = (u != '0) && (u == cur_slot);
        assign dn_hit[i] = (d != '0) && (d == cur_slot);
    end

    // highest used slot, never below 1
    always_comb begin
        up_last = SLOT_W'(1);
        dn_last = SLOT_W'(1);
        for (int i = 0; i < N_OUT; i++) begin
            if (up_cfg[i*SLOT_W +: SLOT_W] > up_last) up_last = up_cfg[i*SLOT_W +: SLOT_W];
            if (dn_cfg[i*SLOT_W +: SLOT_W] > dn_last) dn_last = dn_cfg[i*SLOT_W +: SLOT_W];
        end
    end
endmodule

// File: rtl/pwr_slot_seq.sv
module pwr_slot_seq
    import pseq_pkg::*;
#(
    parameter int N_EN       = 12,
    parameter int SLOT_W     = 4,
    parameter int TMR_W      = 18,
    parameter int STEP_S_US  = 250,
    parameter int STEP_L_US  = 1000,
    parameter int RBASE_S_US = 100,
    parameter int RBASE_L_US = 1000
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   tick_us,
    input  logic                   act_req,
    input  logic                   failsafe,
    input  logic [N_EN*SLOT_W-1:0] up_slot,
    input  logic [N_EN*SLOT_W-1:0] dn_slot,
    input  logic [SLOT_W-1:0]      clk_up_slot,
    input  logic [SLOT_W-1:0]      clk_dn_slot,
    input  logic [7:0]             slot_code,
    input  logic                   step_long,
    input  logic [3:0]             rst_dly_code,
    output logic [N_EN-1:0]        en_out,
    output logic                   clk_en,
    output logic                   rst_out_n,
    output logic                   busy,
    output logic [1:0]             state
);
    localparam int N_OUT = N_EN + 1;

    typedef struct packed {
        phase_e            phase;
        logic [SLOT_W-1:0] slot;
        logic [N_OUT-1:0]  outs;
        logic              rst_n;
    } seq_t;

    seq_t st_d, st_q;

    logic [N_OUT-1:0]  up_hit, dn_hit;
    logic [SLOT_W-1:0] up_last, dn_last;
    logic [TMR_W-1:0]  slot_len, rst_len, tmr_limit;
    logic              tmr_clr, tmr_done;

    pseq_slot_map #(.N_OUT(N_OUT), .SLOT_W(SLOT_W)) u_map (
        .cur_slot (st_q.slot),
        .up_cfg   ({clk_up_slot, up_slot}),
        .dn_cfg   ({clk_dn_slot, dn_slot}),
        .up_hit   (up_hit),
        .dn_hit   (dn_hit),
        .up_last  (up_last),
        .dn_last  (dn_last)
    );

    pseq_len #(
        .TMR_W(TMR_W), .STEP_S_US(STEP_S_US), .STEP_L_US(STEP_L_US),
        .RBASE_S_US(RBASE_S_US), .RBASE_L_US(RBASE_L_US)
    ) u_len (
        .slot_code    (slot_code),
        .step_long    (step_long),
        .rst_dly_code (rst_dly_code),
        .slot_len     (slot_len),
        .rst_len      (rst_len)
    );

    assign tmr_limit = (st_q.phase == PH_HOLD) ? rst_len : slot_len;

    pseq_timer #(.TMR_W(TMR_W)) u_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick_us),
        .clr   (tmr_clr),
        .limit (tmr_limit),
        .done  (tmr_done)
    );

    always_comb begin
        st_d    = st_q;
        tmr_clr = 1'b0;
        unique case (st_q.phase)
            PH_OFF: begin
                if (act_req) begin
                    st_d.phase = PH_UP;
                    st_d.slot  = SLOT_W'(1);
                    tmr_clr    = 1'b1;
                end
            end
            PH_UP: begin
                if (tmr_done) begin
                    st_d.outs = st_q.outs | up_hit;
                    tmr_clr   = 1'b1;
                    if (!act_req) begin
                        st_d.phase = PH_DOWN;
                        st_d.slot  = SLOT_W'(1);
                    end else if (st_q.slot >= up_last) begin
                        st_d.phase = PH_HOLD;
                        st_d.slot  = '0;
                    end else begin
                        st_d.slot = st_q.slot + SLOT_W'(1);
                    end
                end
            end
            PH_HOLD: begin
                if (!act_req) begin
                    st_d.phase = PH_DOWN;
                    st_d.slot  = SLOT_W'(1);
                    tmr_clr    = 1'b1;
                end else if (tmr_done) begin
                    st_d.phase = PH_ON;
                    st_d.rst_n = 1'b1;
                    tmr_clr    = 1'b1;
                end
            end
            PH_ON: begin
                if (!act_req) begin
                    st_d.phase = PH_DOWN;
                    st_d.slot  = SLOT_W'(1);
                    st_d.rst_n = 1'b0;
                    tmr_clr    = 1'b1;
                end
            end
            PH_DOWN: begin
                if (tmr_done) begin
                    st_d.outs = st_q.outs & ~dn_hit;
                    tmr_clr   = 1'b1;
                    if (act_req) begin
                        st_d.phase = PH_UP;
                        st_d.slot  = SLOT_W'(1);
                    end else if (st_q.slot >= dn_last) begin
                        st_d.phase = PH_OFF;
                        st_d.slot  = '0;
                    end else begin
                        st_d.slot = st_q.slot + SLOT_W'(1);
                    end
                end
            end
            default: begin
                st_d.phase = PH_OFF;
                st_d.slot  = '0;
            end
        endcase

        if (failsafe) begin
            st_d.phase = PH_OFF;
            st_d.slot  = '0;
            st_d.outs  = '0;
            st_d.rst_n = 1'b0;
            tmr_clr    = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.phase <= PH_OFF;
            st_q.slot  <= '0;
            st_q.outs  <= '0;
            st_q.rst_n <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign en_out    = st_q.outs[N_EN-1:0];
    assign clk_en    = st_q.outs[N_EN];
    assign rst_out_n = st_q.rst_n;
    assign busy      = (st_q.phase == PH_UP) || (st_q.phase == PH_DOWN);

    always_comb begin
        unique case (st_q.phase)
            PH_UP, PH_HOLD: state = 2'b01;
            PH_ON:          state = 2'b11;
            PH_DOWN:        state = 2'b10;
            default:        state = 2'b00;
        endcase
    end
endmodule

// File: rtl/pwr_slot_seq_chk.sv
module pwr_slot_seq_chk #(
    parameter int N_EN = 12
) (
    input logic            clk,
    input logic            rst_n,
    input logic            act_req,
    input logic            failsafe,
    input logic [N_EN-1:0] en_out,
    input logic            clk_en,
    input logic            rst_out_n,
    input logic            busy,
    input logic [1:0]      state
);
    // R7: failsafe clears every output one edge later
    p_failsafe_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
        failsafe |=> (en_out == '0) && !clk_en && !rst_out_n && (state == 2'b00));

    // R6: reset released only in the active state
    p_rst_only_active_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rst_out_n |-> (state == 2'b11));

    // R6: request drop in active state asserts reset on the next edge
    p_rst_prompt_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == 2'b11 && !act_req) |=> !rst_out_n);

    // R4: nothing rises while powering down
    p_no_rise_down_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == 2'b10) |=> ((en_out & ~$past(en_out)) == '0) && !$rose(clk_en));

    // R3: nothing falls while powering up
    p_no_fall_up_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == 2'b01 && !failsafe) |=> ((~en_out & $past(en_out)) == '0) && !$fell(clk_en));

    // R8: busy only in a transition state
    p_busy_state_r8: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (state == 2'b01 || state == 2'b10));

    // R9: outputs frozen outside slot stepping
    p_idle_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !failsafe) |=> $stable(en_out) && $stable(clk_en));
endmodule

bind pwr_slot_seq pwr_slot_seq_chk #(.N_EN(N_EN)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .act_req   (act_req),
    .failsafe  (failsafe),
    .en_out    (en_out),
    .clk_en    (clk_en),
    .rst_out_n (rst_out_n),
    .busy      (busy),
    .state     (state)
);

// File: tb/tb_pwr_slot_seq.sv
module tb_pwr_slot_seq;
    localparam int N_EN = 12;
    localparam int NW   = N_EN + 3;   // en, clk_en, rst_out_n, busy
    localparam int I_CLK = N_EN, I_RST = N_EN + 1, I_BSY = N_EN + 2;

    logic clk = 0, rst_n = 0, tick_us = 1, act_req = 0, failsafe = 0;
    logic [N_EN*4-1:0] up_slot = '0, dn_slot = '0;
    logic [3:0] clk_up_slot = '0, clk_dn_slot = '0, rst_dly_code = '0;
    logic [7:0] slot_code = '0;
    logic step_long = 0;
    logic [N_EN-1:0] en_out;
    logic clk_en, rst_out_n, busy;
    logic [1:0] state;

    int n_chk = 0, n_fail = 0;
    int fr[NW], ff[NW];

    always #4 clk = ~clk;

    pwr_slot_seq dut (
        .clk(clk), .rst_n(rst_n), .tick_us(tick_us), .act_req(act_req), .failsafe(failsafe),
        .up_slot(up_slot), .dn_slot(dn_slot), .clk_up_slot(clk_up_slot), .clk_dn_slot(clk_dn_slot),
        .slot_code(slot_code), .step_long(step_long), .rst_dly_code(rst_dly_code),
        .en_out(en_out), .clk_en(clk_en), .rst_out_n(rst_out_n), .busy(busy), .state(state)
    );

    // {code, step_long, delay code, expected slot ticks, expected delay ticks}
    localparam int VEC[5][5] = '{
        '{0, 0, 0,  125,  100},
        '{1, 0, 1,  375,  200},
        '{0, 1, 8,  500, 1000},
        '{2, 0, 9,  625, 2000},
        '{3, 1, 0, 3500,  100}
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic set_slot(input int i, input int up, input int dn);
        up_slot[i*4 +: 4] = 4'(up);
        dn_slot[i*4 +: 4] = 4'(dn);
    endtask

    // records the first rise/fall cycle of each watched signal; cycle 1 is the first edge
    task automatic watch(input int cycles, input int drop_at);
        logic [NW-1:0] prev, cur;
        prev = {busy, rst_out_n, clk_en, en_out};
        for (int k = 0; k < NW; k++) begin fr[k] = -1; ff[k] = -1; end
        for (int n = 1; n <= cycles; n++) begin
            @(posedge clk); @(negedge clk);
            cur = {busy, rst_out_n, clk_en, en_out};
            for (int k = 0; k < NW; k++) begin
                if (cur[k] && !prev[k] && fr[k] < 0) fr[k] = n;
                if (!cur[k] && prev[k] && ff[k] < 0) ff[k] = n;
            end
            prev = cur;
            if (n == drop_at) act_req = 0;
        end
    endtask

    initial begin
        #1500000;
        n_fail++; n_chk++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R8 reset state
        chk(en_out == '0 && !clk_en && !rst_out_n, "R8 reset outputs", int'(en_out), 0);
        chk(state == 2'b00 && !busy, "R8 reset state", int'(state), 0);
        rst_n = 1;
        @(negedge clk);

        // table walk: R1 R2 R3 R4 R5 R6 R9 R11
        set_slot(0, 1, 2);
        set_slot(5, 3, 1);
        clk_up_slot = 4'd2; clk_dn_slot = 4'd3;
        for (int v = 0; v < 5; v++) begin
            int L, D;
            slot_code = 8'(VEC[v][0]); step_long = VEC[v][1][0]; rst_dly_code = 4'(VEC[v][2]);
            L = VEC[v][3]; D = VEC[v][4];
            act_req = 1;
            watch(3*L + D + 4, -1);
            chk(fr[0] == L + 1, "R1 slot1 rise", fr[0], L + 1);
            chk(fr[5] == 3*L + 1, "R3 slot3 rise", fr[5], 3*L + 1);
            chk(fr[1] == -1, "R2 unmapped stays low", fr[1], -1);
            chk(fr[I_CLK] == 2*L + 1, "R5 clk enable", fr[I_CLK], 2*L + 1);
            chk(ff[I_BSY] == 3*L + 1, "R9 busy end up", ff[I_BSY], 3*L + 1);
            chk(fr[I_RST] == 3*L + D + 1, "R11 reset delay", fr[I_RST], 3*L + D + 1);
            chk(state == 2'b11, "R8 active code", int'(state), 3);
            act_req = 0;
            watch(3*L + 4, -1);
            chk(ff[I_RST] == 1, "R6 prompt reset", ff[I_RST], 1);
            chk(ff[5] == L + 1, "R4 down slot1", ff[5], L + 1);
            chk(ff[0] == 2*L + 1, "R4 down slot2", ff[0], 2*L + 1);
            chk(ff[I_CLK] == 3*L + 1, "R5 clk disable", ff[I_CLK], 3*L + 1);
            chk(ff[I_BSY] == 3*L + 1, "R9 busy end down", ff[I_BSY], 3*L + 1);
            chk(state == 2'b00, "R8 shutdown code", int'(state), 0);
        end

        // R9: nothing mapped -> one slot, then reset delay
        up_slot = '0; dn_slot = '0; clk_up_slot = '0; clk_dn_slot = '0;
        slot_code = 0; step_long = 0; rst_dly_code = 0;
        act_req = 1;
        watch(240, -1);
        chk(ff[I_BSY] == 126, "R9 empty map one slot", ff[I_BSY], 126);
        chk(fr[I_RST] == 226, "R9 empty map reset", fr[I_RST], 226);
        chk(en_out == '0, "R9 empty map outputs", int'(en_out), 0);
        act_req = 0;
        watch(130, -1);

        // R10: reversal mid-slot 2
        set_slot(0, 1, 2); set_slot(1, 2, 1); set_slot(2, 3, 1);
        act_req = 1;
        watch(520, 135);
        chk(fr[1] == 251, "R10 current slot finished", fr[1], 251);
        chk(fr[2] == -1, "R10 later slot skipped", fr[2], -1);
        chk(ff[1] == 376, "R10 down slot1", ff[1], 376);
        chk(ff[0] == 501, "R10 down slot2", ff[0], 501);
        chk(state == 2'b00, "R10 ends in shutdown", int'(state), 0);

        // R2: slot 0 keeps its level through power-down
        up_slot = '0; dn_slot = '0;
        set_slot(3, 1, 0); set_slot(4, 1, 1);
        act_req = 1;
        watch(240, -1);
        act_req = 0;
        watch(140, -1);
        chk(en_out[3] == 1'b1, "R2 slot 0 keeps high", int'(en_out[3]), 1);
        chk(en_out[4] == 1'b0, "R2 mapped output low", int'(en_out[4]), 0);

        // R7: failsafe
        act_req = 1;
        watch(240, -1);
        failsafe = 1;
        @(posedge clk); @(negedge clk);
        chk(en_out == '0 && !clk_en && !rst_out_n, "R7 all low", int'(en_out), 0);
        chk(state == 2'b00, "R7 state", int'(state), 0);
        repeat (20) @(negedge clk);
        chk(!busy && en_out == '0, "R7 no sequence while held", int'(busy), 0);
        failsafe = 0;
        @(posedge clk); @(negedge clk);
        chk(busy && state == 2'b01, "R7 restart after release", int'(state), 1);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule